// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a ring of transmit descriptors in memory and turns the buffers they point at into a byte stream for a MAC transmitter. Each descriptor is two 32-bit words: a buffer byte address, then a status word. After a start command the block reads a descriptor and checks its "used" bit. It reads the buffer one aligned word at a time and hands the bytes out lowest address first. At the end of a frame it writes the used bit back into the frame's first descriptor. It then moves on to the next descriptor. It stops when it meets a descriptor whose used bit is already set.

Fields of the status word: length in bits 10:0, last-buffer in bit 15, suppress-CRC in bit 16, wrap in bit 30, used in bit 31. The byte stream uses valid/ready. When `tx_valid` is high and `tx_ready` is low, the byte, its last marker and its CRC flag stay unchanged until the sink accepts them. Only a valid/ready handshake moves a byte. The sink may hold `tx_ready` low for any number of cycles. Memory requests are accepted on `mem_req && mem_ready`. Each accepted read returns exactly one word, flagged by `mem_rvalid`, some cycles later. Only one access is outstanding at a time.

Software sees three sticky flags: frame complete, used-bit-read and buffers-exhausted. Each is cleared by pulsing its bit of `txs_clear` (write-one-to-clear). The ring pointer is loaded from `ring_base` by `ring_base_wr` while the block is idle. The ring base must be 8-byte aligned; its low three bits are ignored. Buffers may start at any byte address. Zero-length buffers emit no bytes.

Top module: `txring_dma`

## Requirements
- R1: After reset `busy`, `tx_valid`, `mem_req` and all three status flags are 0.
- R2: A descriptor is fetched as two word reads: the address word at the ring pointer, then the status word at pointer+4. Every memory address issued is word aligned.
- R3: If the first descriptor of a frame has status bit 31 (used) set, no byte is sent. The used-bit-read flag (`txs_used_read`) is set and the block returns to idle.
- R4: A buffer's bytes go out in ascending address order, taking the byte at address a from lane a mod 4 of the little-endian word. The count is status bits 10:0, and the buffer may start at any byte address.
- R5: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R6: `tx_last` is high only on the final byte of the buffer whose status bit 15 (last) is set. A frame may span several buffers.
- R7: `tx_nocrc` carries status bit 16 of the frame's first descriptor on every byte of that frame.
- R8: After the last buffer, the block writes the first descriptor's status word back at its address+4, as read but with bit 31 set. The completion flag (`txs_complete`) rises in the cycle after that write is accepted.
- R9: A descriptor with status bit 30 (wrap) sends the next fetch to `ring_base`; otherwise the next fetch is at pointer+8.
- R10: A used descriptor met in the middle of a frame sets both `txs_exhausted` and `txs_used_read` and stops the block. The pointer goes back to the frame's first descriptor, so the next start re-reads the frame from there.
- R11: `txs_clear` bit 0 clears complete, bit 1 clears used-bit-read and bit 2 clears exhausted. The other flags are left unchanged. A flag set in the same cycle stays set.
- R12: `cmd_start` while `busy` is high has no effect: no extra memory access follows once the block stops.
- R13: `ring_base_wr` while idle makes the next start fetch its first descriptor at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse; honoured only while idle |
| ring_base | input | AW | Ring base byte address (8-byte aligned) |
| ring_base_wr | input | 1 | Load ring pointer from `ring_base` while idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Final byte of frame |
| tx_nocrc | output | 1 | Frame must not get a CRC appended |
| txs_complete | output | 1 | Sticky: a frame completed |
| txs_used_read | output | 1 | Sticky: fetch stopped on a used descriptor |
| txs_exhausted | output | 1 | Sticky: ring ran out in mid-frame |
| txs_clear | input | 3 | Write-one-to-clear for the three flags |
| busy | output | 1 | Block is walking the ring |

## Verification
The bench builds the block with its defaults: 32-bit addresses and an 11-bit length field. With these values, buffers at every byte offset within a word and multi-buffer frames can be placed in a 4 KB memory model. A 40-byte buffer then spans ten word fetches. Memory stalls and a pseudo-random `tx_ready` pattern exercise back-pressure on both sides. The wrap and exhaustion cases use small rings, so the pointer's return to the base or to the frame start shows up at the byte stream and in the addresses of the next fetch.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_W    = 32;
  localparam int USED_BIT  = 31;
  localparam int WRAP_BIT  = 30;
  localparam int NOCRC_BIT = 16;
  localparam int LAST_BIT  = 15;
  localparam int LANES     = DESC_W / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ0, S_DWAIT0, S_DREQ1, S_DWAIT1, S_CHECK,
    S_BREQ, S_BWAIT, S_DRAIN, S_NEXT, S_WB
  } st_e;

  typedef struct packed {
    logic exhausted;
    logic used_read;
    logic complete;
  } flags_t;
endpackage

// File: rtl/txr_unpack.sv
module txr_unpack
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DESC_W-1:0] ld_word,
  input  logic [1:0]        ld_lane,
  input  logic [2:0]        ld_cnt,
  input  logic              ld_last,
  input  logic              ld_nocrc,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [7:0]        o_data,
  output logic              o_last,
  output logic              o_nocrc,
  output logic              empty
);
  logic [DESC_W-1:0] word_q;
  logic [1:0]        lane_q;
  logic [2:0]        left_q;
  logic              last_q, nocrc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      nocrc_q <= 1'b0;
    end else if (ld) begin
      word_q  <= ld_word;
      lane_q  <= ld_lane;
      left_q  <= ld_cnt;
      last_q  <= ld_last;
      nocrc_q <= ld_nocrc;
    end else if (o_valid && o_ready) begin
      lane_q <= lane_q + 2'd1;
      left_q <= left_q - 3'd1;
    end
  end

  assign o_valid = (left_q != 3'd0);
  assign o_data  = word_q[{lane_q, 3'b000} +: 8];
  assign o_last  = last_q && (left_q == 3'd1);
  assign o_nocrc = nocrc_q;
  assign empty   = (left_q == 3'd0);
endmodule

// File: rtl/txr_flags.sv
module txr_flags
  import txr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set_i,
  input  flags_t clr_i,
  output flags_t flags_o
);
  flags_t q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set_i | (q & ~clr_i);
  end

  assign flags_o = q;
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic              base_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DESC_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              ld,
  output logic [1:0]        ld_lane,
  output logic [2:0]        ld_cnt,
  output logic              ld_last,
  output logic              ld_nocrc,
  input  logic              unpack_empty,
  output flags_t            set_o,
  output logic              busy
);
  localparam logic [AW-1:0] DESC_BYTES = AW'(2 * LANES);
  localparam logic [AW-1:0] WORD_BYTES = AW'(LANES);
  localparam logic [AW-1:0] BASE_MASK  = ~(DESC_BYTES - AW'(1));

  st_e               st_q;
  logic [AW-1:0]     ptr_q, fptr_q, baddr_q;
  logic [DESC_W-1:0] dstat_q, fstat_q;
  logic [LEN_W-1:0]  rem_q;
  logic              first_q, nocrc_q;
  logic [AW-1:0]     base_al;
  logic [2:0]        room, take;
  logic              d_used;

  assign base_al = base & BASE_MASK;
  assign d_used  = dstat_q[USED_BIT];
  assign room    = 3'd4 - {1'b0, baddr_q[1:0]};
  assign take    = (rem_q < LEN_W'(room)) ? rem_q[2:0] : room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ptr_q   <= '0;
      fptr_q  <= '0;
      baddr_q <= '0;
      dstat_q <= '0;
      fstat_q <= '0;
      rem_q   <= '0;
      first_q <= 1'b1;
      nocrc_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (base_wr)    ptr_q <= base_al;
          else if (start) st_q  <= S_DREQ0;
        end
        S_DREQ0:  if (mem_ready) st_q <= S_DWAIT0;
        S_DWAIT0: if (mem_rvalid) begin
          baddr_q <= mem_rdata[AW-1:0];
          st_q    <= S_DREQ1;
        end
        S_DREQ1:  if (mem_ready) st_q <= S_DWAIT1;
        S_DWAIT1: if (mem_rvalid) begin
          dstat_q <= mem_rdata;
          st_q    <= S_CHECK;
        end
        S_CHECK: begin
          if (d_used) begin
            if (!first_q) begin
              ptr_q   <= fptr_q;
              first_q <= 1'b1;
            end
            st_q <= S_IDLE;
          end else begin
            if (first_q) begin
              fptr_q  <= ptr_q;
              fstat_q <= dstat_q;
              nocrc_q <= dstat_q[NOCRC_BIT];
              first_q <= 1'b0;
            end
            rem_q <= dstat_q[LEN_W-1:0];
            st_q  <= (dstat_q[LEN_W-1:0] == '0) ? S_NEXT : S_BREQ;
          end
        end
        S_BREQ:  if (mem_ready) st_q <= S_BWAIT;
        S_BWAIT: if (mem_rvalid) begin
          baddr_q <= baddr_q + AW'(take);
          rem_q   <= rem_q - LEN_W'(take);
          st_q    <= S_DRAIN;
        end
        S_DRAIN: if (unpack_empty) st_q <= (rem_q == '0) ? S_NEXT : S_BREQ;
        S_NEXT: begin
          ptr_q <= dstat_q[WRAP_BIT] ? base_al : ptr_q + DESC_BYTES;
          st_q  <= dstat_q[LAST_BIT] ? S_WB : S_DREQ0;
        end
        S_WB: if (mem_ready) begin
          first_q <= 1'b1;
          st_q    <= S_DREQ0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = ptr_q;
    case (st_q)
      S_DREQ0: mem_req = 1'b1;
      S_DREQ1: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + WORD_BYTES;
      end
      S_BREQ: begin
        mem_req  = 1'b1;
        mem_addr = {baddr_q[AW-1:2], 2'b00};
      end
      S_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = fptr_q + WORD_BYTES;
      end
      default: ;
    endcase
  end

  assign mem_wdata = fstat_q | (DESC_W'(1) << USED_BIT);

  assign ld       = (st_q == S_BWAIT) && mem_rvalid;
  assign ld_lane  = baddr_q[1:0];
  assign ld_cnt   = take;
  assign ld_last  = dstat_q[LAST_BIT] && (rem_q == LEN_W'(take));
  assign ld_nocrc = nocrc_q;

  assign set_o.used_read = (st_q == S_CHECK) && d_used;
  assign set_o.exhausted = (st_q == S_CHECK) && d_used && !first_q;
  assign set_o.complete  = (st_q == S_WB) && mem_ready;
  assign busy            = (st_q != S_IDLE);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] ring_base,
  input  logic          ring_base_wr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_nocrc,
  output logic          txs_complete,
  output logic          txs_used_read,
  output logic          txs_exhausted,
  input  logic [2:0]    txs_clear,
  output logic          busy
);
  logic       ld, ld_last, ld_nocrc, unpack_empty;
  logic [1:0] ld_lane;
  logic [2:0] ld_cnt;
  flags_t     set_f, clr_f, flags;

  txr_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(cmd_start),
    .base(ring_base), .base_wr(ring_base_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld(ld), .ld_lane(ld_lane), .ld_cnt(ld_cnt), .ld_last(ld_last),
    .ld_nocrc(ld_nocrc), .unpack_empty(unpack_empty),
    .set_o(set_f), .busy(busy)
  );

  txr_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(mem_rdata),
    .ld_lane(ld_lane), .ld_cnt(ld_cnt), .ld_last(ld_last),
    .ld_nocrc(ld_nocrc), .o_valid(tx_valid), .o_ready(tx_ready),
    .o_data(tx_data), .o_last(tx_last), .o_nocrc(tx_nocrc),
    .empty(unpack_empty)
  );

  assign clr_f.complete  = txs_clear[0];
  assign clr_f.used_read = txs_clear[1];
  assign clr_f.exhausted = txs_clear[2];

  txr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_f), .clr_i(clr_f), .flags_o(flags)
  );

  assign txs_complete  = flags.complete;
  assign txs_used_read = flags.used_read;
  assign txs_exhausted = flags.exhausted;
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_ready,
  input logic [1:0] addr_lo,
  input logic       wdata_used,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       txs_complete
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (addr_lo == 2'b00));

  // R5
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  writeback_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wdata_used);

  // R8
  complete_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txs_complete) |-> $past(mem_req && mem_we && mem_ready));
endmodule

bind txring_dma txring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .addr_lo(mem_addr[1:0]),
  .wdata_used(mem_wdata[31]), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .txs_complete(txs_complete)
);

// File: tb/txring_dma_bench.sv
module txring_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [31:0] ring_base = '0;
  logic        ring_base_wr = 1'b0;
  logic        mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last, tx_nocrc;
  logic [7:0]  tx_data;
  logic        txs_complete, txs_used_read, txs_exhausted, busy;
  logic [2:0]  txs_clear = '0;

  always #4 clk = ~clk;

  txring_dma u_txring_dma (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .ring_base(ring_base),
    .ring_base_wr(ring_base_wr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_nocrc(tx_nocrc), .txs_complete(txs_complete),
    .txs_used_read(txs_used_read), .txs_exhausted(txs_exhausted),
    .txs_clear(txs_clear), .busy(busy)
  );

  int checks = 0, errs = 0;
  logic [31:0] mem [0:1023];
  logic [7:0]  cap_data [0:1023];
  logic        cap_last [0:1023];
  logic        cap_nocrc[0:1023];
  int          cap_n = 0, rd_n = 0, rd_mark = 0, hold_err = 0;
  logic [31:0] first_rd = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [1:0]  mctr = '0;
  logic        stall_en = 1'b0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  assign mem_ready = !stall_en || (mctr != 2'b11);
  assign tx_ready  = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mctr       <= mctr + 2'd1;
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_rvalid <= 1'b0;
      if (mem_req && mem_ready) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else begin
          mem_rdata  <= mem[mem_addr[11:2]];
          mem_rvalid <= 1'b1;
          if (rd_n == rd_mark) first_rd <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
      if (tx_valid && tx_ready) begin
        cap_data[cap_n]  <= tx_data;
        cap_last[cap_n]  <= tx_last;
        cap_nocrc[cap_n] <= tx_nocrc;
        cap_n <= cap_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!tx_valid || tx_data != prev_data)) hold_err <= hold_err + 1;
      prev_stall <= tx_valid && !tx_ready;
      prev_data  <= tx_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input int buf_a, input logic [31:0] st);
    mem[a >> 2]       = buf_a;
    mem[(a >> 2) + 1] = st;
  endtask

  task automatic load_base(input int b);
    @(negedge clk);
    ring_base = b; ring_base_wr = 1'b1;
    @(negedge clk);
    ring_base_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    rd_mark = rd_n;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] c);
    @(negedge clk);
    txs_clear = c;
    @(negedge clk);
    txs_clear = '0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R12", "block returns to idle", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  // compares n captured bytes from index ci against memory bytes at addr a
  task automatic chk_bytes(input string req, input int ci, input int a, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (cap_data[ci + i] != pat(a + i)) bad++;
    chk(bad == 0, req, "byte content", bad, 0);
  endtask

  task automatic chk_last(input string req, input int ci, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (cap_last[ci + i] != (i == n - 1)) bad++;
    chk(bad == 0, req, "last marker placement", bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !tx_valid && !mem_req, "R1", "idle outputs", {busy, tx_valid, mem_req}, 0);
    chk({txs_complete, txs_used_read, txs_exhausted} == 3'b000, "R1", "flags",
        {txs_complete, txs_used_read, txs_exhausted}, 0);
  endtask

  task automatic t_single();
    int c0;
    put_desc(32'h100, 32'h200, 32'h0000_8006);
    put_desc(32'h108, 32'h0, 32'h8000_0000);
    load_base(32'h100);
    c0 = cap_n;
    pulse_start();
    wait_idle();
    chk(first_rd == 32'h100, "R13", "first fetch at base", first_rd, 32'h100);
    chk(rd_n - rd_mark == 6, "R2", "read count", rd_n - rd_mark, 6);
    chk(cap_n - c0 == 6, "R4", "byte count", cap_n - c0, 6);
    chk_bytes("R4", c0, 32'h200, 6);
    chk_last("R6", c0, 6);
    chk(cap_nocrc[c0] == 1'b0, "R7", "crc flag clear", cap_nocrc[c0], 0);
    chk(mem[32'h104 >> 2] == 32'h8000_8006, "R8", "writeback word",
        mem[32'h104 >> 2], 32'h8000_8006);
    chk(txs_complete && txs_used_read && !txs_exhausted, "R3", "flags after stop",
        {txs_complete, txs_used_read, txs_exhausted}, 3'b110);
  endtask

  task automatic t_clear();
    clear_flags(3'b001);
    chk(!txs_complete && txs_used_read, "R11", "clear complete only",
        {txs_complete, txs_used_read}, 2'b01);
    clear_flags(3'b010);
    chk(!txs_used_read, "R11", "clear used-read", txs_used_read, 0);
  endtask

  task automatic t_multi();
    int c0;
    put_desc(32'h108, 32'h301, 32'h0001_0005);
    put_desc(32'h110, 32'h342, 32'h0000_8007);
    put_desc(32'h118, 32'h0, 32'h8000_0000);
    c0 = cap_n;
    pulse_start();
    wait_idle();
    chk(first_rd == 32'h108, "R9", "continues at pointer+8", first_rd, 32'h108);
    chk(cap_n - c0 == 12, "R6", "frame byte count", cap_n - c0, 12);
    chk_bytes("R4", c0, 32'h301, 5);
    chk_bytes("R4", c0 + 5, 32'h342, 7);
    chk_last("R6", c0, 12);
    chk(cap_nocrc[c0] && cap_nocrc[c0 + 11], "R7", "crc flag held",
        {cap_nocrc[c0], cap_nocrc[c0 + 11]}, 2'b11);
    chk(mem[32'h10C >> 2] == 32'h8001_0005, "R8", "writeback to first desc",
        mem[32'h10C >> 2], 32'h8001_0005);
    chk(mem[32'h114 >> 2] == 32'h0000_8007, "R8", "second desc untouched",
        mem[32'h114 >> 2], 32'h0000_8007);
    clear_flags(3'b111);
  endtask

  task automatic t_wrap();
    int c0;
    put_desc(32'h180, 32'h400, 32'h4000_8003);
    put_desc(32'h188, 32'h420, 32'h0000_8002);
    put_desc(32'h190, 32'h0, 32'h8000_0000);
    load_base(32'h180);
    c0 = cap_n;
    pulse_start();
    wait_idle();
    chk(cap_n - c0 == 3, "R9", "wrap stops at used base", cap_n - c0, 3);
    chk_bytes("R9", c0, 32'h400, 3);
    chk(mem[32'h184 >> 2] == 32'hC000_8003, "R9", "wrap desc writeback",
        mem[32'h184 >> 2], 32'hC000_8003);
    chk(txs_used_read, "R3", "used-read after wrap", txs_used_read, 1);
    clear_flags(3'b111);
  endtask

  task automatic t_exhaust();
    int c0;
    put_desc(32'h500, 32'h600, 32'h0000_0004);
    put_desc(32'h508, 32'h0, 32'h8000_0000);
    load_base(32'h500);
    c0 = cap_n;
    pulse_start();
    wait_idle();
    chk(cap_n - c0 == 4, "R10", "bytes before exhaustion", cap_n - c0, 4);
    chk(txs_exhausted && txs_used_read && !txs_complete, "R10", "flags",
        {txs_exhausted, txs_used_read, txs_complete}, 3'b110);
    clear_flags(3'b100);
    chk(!txs_exhausted && txs_used_read, "R11", "clear exhausted only",
        {txs_exhausted, txs_used_read}, 2'b01);
    clear_flags(3'b111);
    put_desc(32'h508, 32'h640, 32'h0000_8002);
    put_desc(32'h510, 32'h0, 32'h8000_0000);
    c0 = cap_n;
    pulse_start();
    wait_idle();
    chk(first_rd == 32'h500, "R10", "restart at frame start", first_rd, 32'h500);
    chk(cap_n - c0 == 6, "R10", "retried frame length", cap_n - c0, 6);
    chk_bytes("R10", c0, 32'h600, 4);
    chk_bytes("R10", c0 + 4, 32'h640, 2);
    chk_last("R6", c0, 6);
    clear_flags(3'b111);
  endtask

  task automatic t_start_busy();
    int c0;
    put_desc(32'h700, 32'h800, 32'h0000_8028);
    put_desc(32'h708, 32'h0, 32'h8000_0000);
    load_base(32'h700);
    stall_en = 1'b1;
    c0 = cap_n;
    pulse_start();
    repeat (10) @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(!busy, "R12", "stays idle", busy, 0);
    chk(rd_n - rd_mark == 14, "R12", "no extra fetch", rd_n - rd_mark, 14);
    chk(cap_n - c0 == 40, "R4", "long buffer count", cap_n - c0, 40);
    chk_bytes("R4", c0, 32'h800, 40);
    chk(hold_err == 0, "R5", "stream held under back-pressure", hold_err, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] = {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_clear();
    t_multi();
    t_wrap();
    t_exhaust();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule